// File: doc/BRIEF.md
# DMA Channel Interrupt and Enable Register Block

This block keeps the interrupt state and the run-enable bits for a DMA controller with up to eight channels. The channel engines pulse event inputs in five classes: transfer done, block done, source-side transaction done, destination-side transaction done, and error. Each pulse latches a raw bit for its channel and class. Software reads the raw bits, or the raw bits filtered through a per-class mask. It acknowledges an event by writing ones to a write-only clear register. A summary register shows which classes have any unmasked event pending, and a single interrupt line reports this to the processor once the global enable is on.

Mask and channel-enable writes carry a per-channel write-enable byte in bits [15:8] next to the value byte in bits [7:0]. Software can therefore set or clear one channel's bit without first reading the register. A channel's enable bit drops by itself when the engine reports that the channel's transfer has finished.

The register port is a single-cycle write strobe with a 6-bit word address. Read data is combinational from the address.

Top module: `dma_irq_regs`

## Requirements
- R1: Event input bit `ev_i[c*NCH+k]` belongs to channel k of class c, with class codes transfer=0, block=1, source transaction=2, destination transaction=3, error=4. In every per-channel register, channel k owns bit k.
- R2: An event pulse sets the matching raw bit at the next clock edge, whatever the mask holds. The raw register of class c reads at address 0x00+c.
- R3: The status register of class c, at address 0x08+c, reads as the raw bits ANDed with the mask bits.
- R4: The mask register of class c, at address 0x10+c, resets to 0. A write changes only the channels whose bit in wdata[15:8] is 1, and loads those channels from wdata[7:0]. A 1 in the mask enables that channel's interrupt.
- R5: Writing to the clear register of class c, at address 0x18+c, clears each raw bit whose wdata[7:0] bit is 1. The clear register always reads 0.
- R6: When an event and a clear of the same raw bit occur in the same cycle, the raw bit ends up set.
- R7: The summary register at 0x20 has bit c set when class c has any status bit set.
- R8: The configuration register at 0x21 holds the controller enable in bit 0 and resets to 0. `irq_o` is high exactly when this enable is 1 and some status bit is set.
- R9: The channel-enable register at 0x22 resets to 0, is written with the same write-enable scheme as R4, and drives `ch_en_o`. A `ch_done_i` pulse clears that channel's bit. A write to the same bit in the same cycle takes precedence over the pulse.
- R10: Reads of unmapped addresses (class codes 5 to 7 in the first four groups, and 0x23 to 0x3F) return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_addr | input | 6 | Word address for read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| ev_i | input | 5*NCH | Event pulses, class-major |
| ch_done_i | input | NCH | Per-channel transfer-finished pulses |
| ch_en_o | output | NCH | Channel enable bits |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The assertions assume that `ev_i` and `ch_done_i` are low while reset is held. They also assume that a raw bit can only fall in a cycle that carries a register write, and that the enable bits move only on a write or a done pulse. The bench drives every input on the falling clock edge and holds all event, done and write inputs at zero during reset. It raises events only through one-cycle pulse tasks. The event-versus-clear and done-versus-write collisions are produced on purpose by tasks that drive both inputs in the same cycle.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
    localparam int NCLS   = 5;
    localparam int MAX_CH = 8;
    localparam int AW     = 6;
    localparam int DW     = 32;

    typedef enum logic [2:0] {
        GRP_RAW  = 3'd0,
        GRP_STAT = 3'd1,
        GRP_MASK = 3'd2,
        GRP_CLR  = 3'd3,
        GRP_MISC = 3'd4
    } grp_e;

    localparam logic [2:0] MISC_SUMMARY = 3'd0;
    localparam logic [2:0] MISC_CFG     = 3'd1;
    localparam logic [2:0] MISC_CHEN    = 3'd2;
    localparam int         WE_LSB       = 8;
endpackage

// File: rtl/dma_irq_decode.sv
module dma_irq_decode
    import dma_irq_pkg::*;
(
    input  logic          wr,
    input  logic [AW-1:0] addr,
    output logic [NCLS-1:0] clr_sel,
    output logic [NCLS-1:0] mask_sel,
    output logic          cfg_sel,
    output logic          chen_sel
);
    logic [2:0] grp;
    logic [2:0] idx;

    assign grp = addr[5:3];
    assign idx = addr[2:0];

    always_comb begin
        clr_sel  = '0;
        mask_sel = '0;
        cfg_sel  = 1'b0;
        chen_sel = 1'b0;
        if (wr) begin
            for (int c = 0; c < NCLS; c++) begin
                if (idx == 3'(c)) begin
                    clr_sel[c]  = (grp == GRP_CLR);
                    mask_sel[c] = (grp == GRP_MASK);
                end
            end
            cfg_sel  = (grp == GRP_MISC) && (idx == MISC_CFG);
            chen_sel = (grp == GRP_MISC) && (idx == MISC_CHEN);
        end
    end
endmodule

// File: rtl/dma_irq_class.sv
module dma_irq_class #(
    parameter int NCH = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] ev,
    input  logic [NCH-1:0] clr,
    input  logic [NCH-1:0] mask_we,
    input  logic [NCH-1:0] mask_val,
    output logic [NCH-1:0] raw,
    output logic [NCH-1:0] mask,
    output logic [NCH-1:0] stat
);
    typedef struct packed {
        logic [NCH-1:0] raw;
        logic [NCH-1:0] mask;
    } cls_st_t;

    cls_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.raw  = (st_q.raw & ~clr) | ev;
        st_d.mask = (st_q.mask & ~mask_we) | (mask_val & mask_we);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign raw  = st_q.raw;
    assign mask = st_q.mask;
    assign stat = st_q.raw & st_q.mask;
endmodule

// File: rtl/dma_chen_reg.sv
module dma_chen_reg #(
    parameter int NCH = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] we,
    input  logic [NCH-1:0] val,
    input  logic [NCH-1:0] done,
    output logic [NCH-1:0] en
);
    typedef struct packed {
        logic [NCH-1:0] en;
    } chen_st_t;

    chen_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.en = ((st_q.en & ~done) & ~we) | (val & we);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign en = st_q.en;
endmodule

// File: rtl/dma_irq_regs.sv
module dma_irq_regs
    import dma_irq_pkg::*;
#(
    parameter int NCH = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr,
    input  logic [AW-1:0]       reg_addr,
    input  logic [DW-1:0]       reg_wdata,
    output logic [DW-1:0]       reg_rdata,
    input  logic [NCLS*NCH-1:0] ev_i,
    input  logic [NCH-1:0]      ch_done_i,
    output logic [NCH-1:0]      ch_en_o,
    output logic                irq_o
);
    localparam int FLAT = NCLS * NCH;

    typedef struct packed {
        logic glb_en;
    } top_st_t;

    top_st_t st_d, st_q;

    logic [NCLS-1:0] clr_sel, mask_sel, summary;
    logic            cfg_sel, chen_sel;
    logic [NCH-1:0]  wr_val, wr_we;
    logic [NCH-1:0]  raw_a  [NCLS];
    logic [NCH-1:0]  mask_a [NCLS];
    logic [NCH-1:0]  stat_a [NCLS];
    logic [FLAT-1:0] raw_flat, mask_flat;
    logic            unused_hi;

    assign wr_val    = reg_wdata[NCH-1:0];
    assign wr_we     = reg_wdata[WE_LSB +: NCH];
    assign unused_hi = ^reg_wdata[DW-1:16];

    dma_irq_decode u_dec (
        .wr       (reg_wr),
        .addr     (reg_addr),
        .clr_sel  (clr_sel),
        .mask_sel (mask_sel),
        .cfg_sel  (cfg_sel),
        .chen_sel (chen_sel)
    );

    for (genvar c = 0; c < NCLS; c++) begin : g_cls
        dma_irq_class #(.NCH(NCH)) u_cls (
            .clk      (clk),
            .rst_n    (rst_n),
            .ev       (ev_i[c*NCH +: NCH]),
            .clr      (clr_sel[c] ? wr_val : '0),
            .mask_we  (mask_sel[c] ? wr_we : '0),
            .mask_val (wr_val),
            .raw      (raw_a[c]),
            .mask     (mask_a[c]),
            .stat     (stat_a[c])
        );
        assign summary[c]              = |stat_a[c];
        assign raw_flat[c*NCH +: NCH]  = raw_a[c];
        assign mask_flat[c*NCH +: NCH] = mask_a[c];
    end

    dma_chen_reg #(.NCH(NCH)) u_chen (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (chen_sel ? wr_we : '0),
        .val  (wr_val),
        .done (ch_done_i),
        .en   (ch_en_o)
    );

    always_comb begin
        st_d = st_q;
        if (cfg_sel) st_d.glb_en = reg_wdata[0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_o = st_q.glb_en && (|summary);

    always_comb begin
        reg_rdata = '0;
        case (reg_addr[5:3])
            GRP_RAW, GRP_STAT, GRP_MASK: begin
                for (int c = 0; c < NCLS; c++) begin
                    if (reg_addr[2:0] == 3'(c)) begin
                        if (reg_addr[5:3] == GRP_RAW)       reg_rdata[NCH-1:0] = raw_a[c];
                        else if (reg_addr[5:3] == GRP_STAT) reg_rdata[NCH-1:0] = stat_a[c];
                        else                                reg_rdata[NCH-1:0] = mask_a[c];
                    end
                end
            end
            GRP_MISC: begin
                if (reg_addr[2:0] == MISC_SUMMARY)   reg_rdata[NCLS-1:0] = summary;
                else if (reg_addr[2:0] == MISC_CFG)  reg_rdata[0]        = st_q.glb_en;
                else if (reg_addr[2:0] == MISC_CHEN) reg_rdata[NCH-1:0]  = ch_en_o;
            end
            default: reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/dma_irq_regs_chk.sv
module dma_irq_regs_chk #(
    parameter int NCH  = 8,
    parameter int FLAT = 40
) (
    input logic            clk,
    input logic            rst_n,
    input logic            reg_wr,
    input logic [FLAT-1:0] ev_i,
    input logic [NCH-1:0]  ch_done_i,
    input logic [NCH-1:0]  ch_en_o,
    input logic            irq_o,
    input logic            glb_en,
    input logic [FLAT-1:0] raw_flat,
    input logic [FLAT-1:0] mask_flat
);
    logic past_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    AST_EVENT_SETS_RAW: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> ((raw_flat & $past(ev_i)) == $past(ev_i)));              // R2
    AST_EVENT_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(reg_wr)) |-> ((raw_flat & $past(ev_i)) == $past(ev_i))); // R6
    AST_RAW_RISE_NEEDS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> ((raw_flat & ~$past(raw_flat) & ~$past(ev_i)) == '0));   // R1
    AST_RAW_FALL_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !$past(reg_wr)) |-> ((~raw_flat & $past(raw_flat)) == '0)); // R5
    AST_MASK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !$past(reg_wr)) |-> (mask_flat == $past(mask_flat)));    // R4
    AST_IRQ_RAISED: assert property (@(posedge clk) disable iff (!rst_n)
        (glb_en && ((raw_flat & mask_flat) != '0)) |-> irq_o);               // R8
    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !glb_en |-> !irq_o);                                                 // R8
    AST_DONE_DROPS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !$past(reg_wr)) |-> ((ch_en_o & $past(ch_done_i)) == '0)); // R9
    AST_EN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !$past(reg_wr) && ($past(ch_done_i) == '0)) |-> $stable(ch_en_o)); // R9
endmodule

bind dma_irq_regs dma_irq_regs_chk #(.NCH(NCH), .FLAT(NCLS*NCH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .ev_i      (ev_i),
    .ch_done_i (ch_done_i),
    .ch_en_o   (ch_en_o),
    .irq_o     (irq_o),
    .glb_en    (st_q.glb_en),
    .raw_flat  (raw_flat),
    .mask_flat (mask_flat)
);

// File: tb/dma_irq_regs_test.sv
`timescale 1ns/1ps
module dma_irq_regs_test;
    localparam int NCH = 8;
    localparam int NC  = 5;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              reg_wr = 1'b0;
    logic [5:0]        reg_addr = '0;
    logic [31:0]       reg_wdata = '0;
    logic [31:0]       reg_rdata;
    logic [NC*NCH-1:0] ev_i = '0;
    logic [NCH-1:0]    ch_done_i = '0;
    logic [NCH-1:0]    ch_en_o;
    logic              irq_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    dma_irq_regs #(.NCH(NCH)) uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ev_i(ev_i),
        .ch_done_i(ch_done_i), .ch_en_o(ch_en_o), .irq_o(irq_o)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One cycle with optional write, event and done pulses.
    task automatic cyc(logic w, logic [5:0] a, logic [31:0] d,
                       logic [NC*NCH-1:0] ev, logic [NCH-1:0] dn);
        @(negedge clk);
        reg_wr = w; reg_addr = a; reg_wdata = d; ev_i = ev; ch_done_i = dn;
        @(negedge clk);
        reg_wr = 1'b0; ev_i = '0; ch_done_i = '0;
    endtask

    task automatic wr(logic [5:0] a, logic [31:0] d);
        cyc(1'b1, a, d, '0, '0);
    endtask

    task automatic rd(logic [5:0] a, output logic [31:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    function automatic logic [NC*NCH-1:0] evb(int c, int k);
        logic [NC*NCH-1:0] v = '0;
        v[c*NCH + k] = 1'b1;
        return v;
    endfunction

    task automatic t_reset();
        logic [31:0] v;
        rd(6'h00, v); check("R2 raw reset", v, 0);
        rd(6'h10, v); check("R4 mask reset", v, 0);
        rd(6'h21, v); check("R8 cfg reset", v, 0);
        rd(6'h22, v); check("R9 chen reset", v, 0);
        check("R8 irq reset", {31'b0, irq_o}, 0);
    endtask

    task automatic t_raw_status();
        logic [31:0] v;
        cyc(1'b0, 6'h00, 0, evb(1, 3), '0);
        rd(6'h01, v); check("R2 R1 block raw ch3", v, 32'h08);
        rd(6'h00, v); check("R1 other class untouched", v, 0);
        rd(6'h09, v); check("R3 status masked off", v, 0);
        wr(6'h11, 32'hFF08);
        rd(6'h09, v); check("R3 status unmasked", v, 32'h08);
        rd(6'h20, v); check("R7 summary block", v, 32'h02);
        check("R8 irq off while disabled", {31'b0, irq_o}, 0);
        wr(6'h21, 32'h1);
        rd(6'h21, v); check("R8 cfg readback", v, 1);
        check("R8 irq on", {31'b0, irq_o}, 1);
    endtask

    task automatic t_mask_we();
        logic [31:0] v;
        wr(6'h11, 32'h0101);
        rd(6'h11, v); check("R4 partial set", v, 32'h09);
        wr(6'h11, 32'h00FF);
        rd(6'h11, v); check("R4 no we no change", v, 32'h09);
        wr(6'h11, 32'h0800);
        rd(6'h11, v); check("R4 clear one ch", v, 32'h01);
        check("R8 irq drops with mask", {31'b0, irq_o}, 0);
        wr(6'h11, 32'h0808);
    endtask

    task automatic t_clear();
        logic [31:0] v;
        rd(6'h19, v); check("R5 clear reads zero", v, 0);
        wr(6'h19, 32'h04);
        rd(6'h01, v); check("R5 clear other bit", v, 32'h08);
        wr(6'h19, 32'h08);
        rd(6'h01, v); check("R5 cleared", v, 0);
        check("R8 irq after clear", {31'b0, irq_o}, 0);
    endtask

    task automatic t_race();
        logic [31:0] v;
        cyc(1'b0, 6'h00, 0, evb(4, 6), '0);
        cyc(1'b1, 6'h1C, 32'h40, evb(4, 6), '0);
        rd(6'h04, v); check("R6 event beats clear", v, 32'h40);
        wr(6'h1C, 32'h40);
        rd(6'h04, v); check("R6 later clear", v, 0);
    endtask

    task automatic t_summary();
        logic [31:0] v;
        cyc(1'b0, 6'h00, 0, evb(0, 7) | evb(3, 0), '0);
        rd(6'h00, v); check("R1 xfer ch7", v, 32'h80);
        rd(6'h03, v); check("R1 dst txn ch0", v, 32'h01);
        wr(6'h10, 32'h8080);
        wr(6'h13, 32'h0101);
        rd(6'h20, v); check("R7 summary two classes", v, 32'h09);
        check("R8 irq two classes", {31'b0, irq_o}, 1);
        wr(6'h21, 32'h0);
        check("R8 irq gated by enable", {31'b0, irq_o}, 0);
        rd(6'h08, v); check("R3 status kept when disabled", v, 32'h80);
    endtask

    task automatic t_chen();
        logic [31:0] v;
        wr(6'h22, 32'h0F05);
        check("R9 enable write", {24'b0, ch_en_o}, 32'h05);
        cyc(1'b0, 6'h00, 0, '0, 8'h01);
        rd(6'h22, v); check("R9 done clears", v, 32'h04);
        cyc(1'b1, 6'h22, 32'h0404, '0, 8'h04);
        check("R9 write beats done", {24'b0, ch_en_o}, 32'h04);
        cyc(1'b0, 6'h00, 0, '0, 8'h04);
        check("R9 done clears last", {24'b0, ch_en_o}, 0);
    endtask

    task automatic t_unmapped();
        logic [31:0] v;
        rd(6'h05, v); check("R10 raw class5", v, 0);
        rd(6'h0F, v); check("R10 stat class7", v, 0);
        rd(6'h23, v); check("R10 misc 0x23", v, 0);
        rd(6'h3F, v); check("R10 top address", v, 0);
    endtask

    initial begin
        #(200000 * 4);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_raw_status();
        t_mask_we();
        t_clear();
        t_race();
        t_summary();
        t_chen();
        t_unmapped();
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule